// File: doc/BRIEF.md
# Trace Sample Word Packer

This block sits between a processor trace port and a capture memory. Each clock cycle it may take one trace sample: a 3-bit pipeline status, a packet field and a sync flag. It gathers the samples into 32-bit words. How many samples share a word depends on the configured port width: three samples at 4 bits, two at 8 bits, one at 16 bits. A word is handed out with a one-cycle valid strobe as soon as its last slot is taken.

A flush input closes a partly filled word early. Empty slots in that word stay zero. The width and port style are sampled only on the first cycle after reset or after a flush, so the layout can never change in the middle of a word. Two configurations are refused and reported: a multiplexed port, and a demultiplexed port at any width other than 8 bits. While one of them is active, every sample is discarded.

Top module: `trpk_packer`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `word_vld_o` is 0. The first sample accepted after reset goes into slot 0.
- R2: At 16-bit width (`mode_i`=2) every sample forms a word by itself: status in [2:0], packet in [18:3], sync in [19], and bits [31:20] zero.
- R3: At 8-bit width (`mode_i`=1) two samples form a word. The earlier one has status [2:0], packet [10:3] and sync [11]. The later one has status [14:12], packet [22:15] and sync [23].
- R4: At 4-bit width (`mode_i`=0) three samples form a word, in 8-bit slots that start at bits 0, 8 and 16 in arrival order. Each slot holds status in its low 3 bits, then 4 packet bits, then sync in its top bit.
- R5: `style_i` encodes 0 = plain, 1 = demultiplexed, 2 = multiplexed, 3 = reserved. The configuration is refused when the style is 2 or 3, when `mode_i` is 3, or when the style is 1 and `mode_i` is not 1. While a refused configuration is active, `cfg_bad_o` is 1, samples are discarded and no word is produced.
- R6: `word_vld_o` rises on the cycle that follows the clock edge capturing the last sample of a word, and lasts one cycle unless the next word also completes. Words may complete on consecutive cycles.
- R7: Packet bits above the active width are ignored. Bits [31:24] of every word are zero.
- R8: When `flush_i` is 1 and a sample is pending or arriving, the word is emitted on the next cycle. A sample that arrives in the flush cycle is included. Empty slots read zero, and the next sample starts at slot 0. A flush with nothing pending produces no word.
- R9: A new `mode_i` or `style_i` value is taken only on the first cycle after reset or after a flush cycle. Changes at any other time have no effect on the layout.
- R10: A cycle with `smp_vld_i` at 0 and no flush leaves the word under construction unchanged and produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Port width: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = invalid |
| style_i | input | 2 | Port style: 0 = plain, 1 = demultiplexed, 2 = multiplexed, 3 = reserved |
| smp_vld_i | input | 1 | A sample is present this cycle |
| smp_stat_i | input | 3 | Pipeline status of the sample |
| smp_pkt_i | input | 16 | Packet field; only the low bits for the active width are used |
| smp_sync_i | input | 1 | Sync flag of the sample |
| flush_i | input | 1 | Emit the partial word and re-sample the configuration |
| word_o | output | 32 | Packed word |
| word_vld_o | output | 1 | `word_o` is valid this cycle |
| cfg_bad_o | output | 1 | The active configuration is refused |

## Verification
A flush and a sample arriving in the same cycle can coincide, and so can a flush and the completion of a full word. The bench drives a sample together with `flush_i` while one slot is already occupied. The emitted word must then carry both samples in slots 0 and 1 with the upper slot zero, and the next sample must restart at slot 0. A width change applied in the middle of a word, followed by a flush, also checks that the old layout is used for the flushed word and the new one only for the word after it.

// File: rtl/trpk_pkg.sv
package trpk_pkg;

  localparam int WORD_W    = 32;
  localparam int STAT_W    = 3;
  localparam int PKT_MAX   = 16;
  localparam int MAX_SLOTS = 3;
  localparam int CNT_W     = $clog2(MAX_SLOTS + 1);

  typedef enum logic [1:0] {
    WID4  = 2'd0,
    WID8  = 2'd1,
    WID16 = 2'd2,
    WIDX  = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    ST_PLAIN = 2'd0,
    ST_DEMUX = 2'd1,
    ST_MUX   = 2'd2,
    ST_RSV   = 2'd3
  } style_e;

  typedef struct packed {
    width_e wid;
    style_e sty;
  } cfg_t;

  // packet bits carried per sample
  function automatic int pkt_width(width_e w);
    case (w)
      WID4:    return 4;
      WID8:    return 8;
      WID16:   return 16;
      default: return 0;
    endcase
  endfunction

  // distance in bits between consecutive slot bases
  function automatic int slot_pitch(width_e w);
    case (w)
      WID4:    return 8;
      WID8:    return 12;
      default: return 0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] slots_per_word(width_e w);
    case (w)
      WID4:    return CNT_W'(3);
      WID8:    return CNT_W'(2);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic logic cfg_legal(cfg_t c);
    logic ok;
    ok = (c.wid != WIDX);
    ok = ok && ((c.sty == ST_PLAIN) || (c.sty == ST_DEMUX));
    ok = ok && ((c.sty != ST_DEMUX) || (c.wid == WID8));
    return ok;
  endfunction

  // one sample positioned at its slot inside an otherwise zero word
  function automatic logic [WORD_W-1:0] place_slot(width_e w, int slot,
                                                  logic [STAT_W-1:0] st,
                                                  logic [PKT_MAX-1:0] pk,
                                                  logic sy);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] s;
    int pw;
    pw   = pkt_width(w);
    mask = (WORD_W'(1) << pw) - WORD_W'(1);
    s    = WORD_W'(st);
    s    = s | ((WORD_W'(pk) & mask) << STAT_W);
    s    = s | (WORD_W'(sy) << (STAT_W + pw));
    if (pw == 0) s = '0;
    return s << (slot_pitch(w) * slot);
  endfunction

endpackage

// File: rtl/trpk_cfg_hold.sv
module trpk_cfg_hold
  import trpk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush_i,
  input  width_e wid_i,
  input  style_e sty_i,
  output cfg_t   eff_o,
  output logic   legal_o
);

  logic reload_q;
  cfg_t act_q;
  cfg_t eff_w;

  // the live inputs are used only on the cycle after reset or after a flush
  always_comb begin
    if (reload_q) begin
      eff_w.wid = wid_i;
      eff_w.sty = sty_i;
    end else begin
      eff_w = act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q  <= 1'b1;
      act_q.wid <= WID16;
      act_q.sty <= ST_PLAIN;
    end else begin
      reload_q <= flush_i;
      act_q    <= eff_w;
    end
  end

  assign eff_o   = eff_w;
  assign legal_o = cfg_legal(eff_w);

endmodule

// File: rtl/trpk_slot_ctr.sv
module trpk_slot_ctr #(
  parameter int CNT_W = trpk_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] spw_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (accept_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == (spw_i - CNT_W'(1)));

endmodule

// File: rtl/trpk_lane_merge.sv
module trpk_lane_merge
  import trpk_pkg::*;
#(
  parameter int N_SLOTS = MAX_SLOTS,
  parameter int CW      = CNT_W
) (
  input  width_e             wid_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic [STAT_W-1:0]  stat_i,
  input  logic [PKT_MAX-1:0] pkt_i,
  input  logic               sync_i,
  output logic [WORD_W-1:0]  slot_bits_o
);

  logic [WORD_W-1:0] cand [N_SLOTS];

  // every slot position is formed in parallel, the counter picks one
  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign cand[k] = place_slot(wid_i, k, stat_i, pkt_i, sync_i);
  end

  always_comb begin
    slot_bits_o = '0;
    for (int k = 0; k < N_SLOTS; k++) begin
      if (cnt_i == CW'(k)) slot_bits_o = cand[k];
    end
  end

endmodule

// File: rtl/trpk_word_acc.sv
module trpk_word_acc #(
  parameter int W = trpk_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic         emit_i,
  input  logic [W-1:0] slot_bits_i,
  output logic [W-1:0] word_o,
  output logic         vld_o
);

  logic [W-1:0] acc_q;
  logic [W-1:0] word_q;
  logic         vld_q;
  logic [W-1:0] nxt_w;

  assign nxt_w = acc_q | (accept_i ? slot_bits_i : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= emit_i;
      if (emit_i) begin
        word_q <= nxt_w;
        acc_q  <= '0;
      end else if (accept_i) begin
        acc_q <= nxt_w;
      end
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/trpk_packer.sv
module trpk_packer
  import trpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic [1:0]  style_i,
  input  logic        smp_vld_i,
  input  logic [2:0]  smp_stat_i,
  input  logic [15:0] smp_pkt_i,
  input  logic        smp_sync_i,
  input  logic        flush_i,
  output logic [31:0] word_o,
  output logic        word_vld_o,
  output logic        cfg_bad_o
);

  cfg_t             eff_cfg_w;
  logic             cfg_ok_w;
  logic [CNT_W-1:0] spw_w;
  logic [CNT_W-1:0] cnt_w;
  logic             last_w;
  logic             accept_w;
  logic             pending_w;
  logic             emit_w;
  logic [WORD_W-1:0] slot_bits_w;
  width_e           eff_wid_w;

  trpk_cfg_hold u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_i),
    .wid_i   (width_e'(mode_i)),
    .sty_i   (style_e'(style_i)),
    .eff_o   (eff_cfg_w),
    .legal_o (cfg_ok_w)
  );

  assign eff_wid_w = eff_cfg_w.wid;
  assign spw_w     = slots_per_word(eff_wid_w);

  // named events, also observed by the checker
  assign accept_w  = smp_vld_i && cfg_ok_w;
  assign pending_w = (cnt_w != '0) || accept_w;
  assign emit_w    = (accept_w && last_w) || (flush_i && pending_w);

  trpk_slot_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .clear_i  (emit_w),
    .spw_i    (spw_w),
    .cnt_o    (cnt_w),
    .last_o   (last_w)
  );

  trpk_lane_merge #(.N_SLOTS(MAX_SLOTS), .CW(CNT_W)) u_lane (
    .wid_i       (eff_wid_w),
    .cnt_i       (cnt_w),
    .stat_i      (smp_stat_i),
    .pkt_i       (smp_pkt_i),
    .sync_i      (smp_sync_i),
    .slot_bits_o (slot_bits_w)
  );

  trpk_word_acc #(.W(WORD_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_w),
    .emit_i      (emit_w),
    .slot_bits_i (slot_bits_w),
    .word_o      (word_o),
    .vld_o       (word_vld_o)
  );

  assign cfg_bad_o = !cfg_ok_w;

endmodule

// File: rtl/trpk_checker.sv
module trpk_checker #(
  parameter int CW = trpk_pkg::CNT_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld_i,
  input logic          flush_i,
  input logic [31:0]   word_o,
  input logic          word_vld_o,
  input logic          cfg_bad_o,
  input logic          accept,
  input logic          last,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] spw,
  input logic [1:0]    eff_wid
);

  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < spw);

  assert_full_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && last |=> word_vld_o);

  assert_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> word_o[31:24] == 8'h00);

  assert_wide_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o && ($past(eff_wid) == 2'd2) |-> word_o[31:20] == 12'h000);

  assert_bad_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad_o |=> !word_vld_o);

  assert_bad_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad_o |-> cnt == '0);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> cnt == '0);

  assert_empty_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i && (cnt == '0) && !accept |=> !word_vld_o);

  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> eff_wid == $past(eff_wid));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i && !flush_i |=> $stable(cnt) && !word_vld_o);

endmodule

bind trpk_packer trpk_checker #(.CW(trpk_pkg::CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_vld_i  (smp_vld_i),
  .flush_i    (flush_i),
  .word_o     (word_o),
  .word_vld_o (word_vld_o),
  .cfg_bad_o  (cfg_bad_o),
  .accept     (accept_w),
  .last       (last_w),
  .cnt        (cnt_w),
  .spw        (spw_w),
  .eff_wid    (eff_wid_w)
);

// File: tb/sim_trpk_packer.sv
module sim_trpk_packer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd2;
  logic [1:0]  style_i = 2'd0;
  logic        smp_vld_i = 1'b0;
  logic [2:0]  smp_stat_i = '0;
  logic [15:0] smp_pkt_i = '0;
  logic        smp_sync_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] word_o;
  logic        word_vld_o;
  logic        cfg_bad_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  trpk_packer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .style_i    (style_i),
    .smp_vld_i  (smp_vld_i),
    .smp_stat_i (smp_stat_i),
    .smp_pkt_i  (smp_pkt_i),
    .smp_sync_i (smp_sync_i),
    .flush_i    (flush_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .cfg_bad_o  (cfg_bad_o)
  );

  // expected slot image, built by concatenation
  function automatic logic [31:0] exp_slot(int m, int k, logic [2:0] st,
                                          logic [15:0] pk, logic sy);
    logic [31:0] v;
    case (m)
      0: v = 32'({sy, pk[3:0], st}) << (8 * k);
      1: v = 32'({sy, pk[7:0], st}) << (12 * k);
      default: v = 32'({sy, pk, st});
    endcase
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic v, logic [2:0] st, logic [15:0] pk, logic sy, logic fl);
    @(negedge clk);
    smp_vld_i  = v;
    smp_stat_i = st;
    smp_pkt_i  = pk;
    smp_sync_i = sy;
    flush_i    = fl;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 3'd5, 16'hBEEF, 1'b1, 1'b0);
  endtask

  task automatic do_reset(logic [1:0] m, logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    mode_i = m;
    style_i = s;
    smp_vld_i = 1'b0;
    flush_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 vld in reset", 32'(word_vld_o), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(2'd1, 2'd0);
    idle();
    chk("R1 vld after reset", 32'(word_vld_o), 32'd0);
    chk("R1 cfg ok", 32'(cfg_bad_o), 32'd0);
  endtask

  task automatic t_wide16();
    do_reset(2'd2, 2'd0);
    step(1'b1, 3'd6, 16'hA5C3, 1'b1, 1'b0);
    chk("R2 vld", 32'(word_vld_o), 32'd1);
    chk("R2 word", word_o, exp_slot(2, 0, 3'd6, 16'hA5C3, 1'b1));
    step(1'b1, 3'd1, 16'h0F0F, 1'b0, 1'b0);
    chk("R6 back-to-back vld", 32'(word_vld_o), 32'd1);
    chk("R2 second word", word_o, exp_slot(2, 0, 3'd1, 16'h0F0F, 1'b0));
    idle();
    chk("R6 vld drop", 32'(word_vld_o), 32'd0);
  endtask

  task automatic t_mid8();
    do_reset(2'd1, 2'd0);
    step(1'b1, 3'd3, 16'hFF5A, 1'b1, 1'b0);
    chk("R3 no word yet", 32'(word_vld_o), 32'd0);
    step(1'b1, 3'd7, 16'h12C4, 1'b0, 1'b0);
    chk("R3 vld", 32'(word_vld_o), 32'd1);
    chk("R3 word", word_o, exp_slot(1, 0, 3'd3, 16'h005A, 1'b1) |
                          exp_slot(1, 1, 3'd7, 16'h00C4, 1'b0));
    step(1'b1, 3'd2, 16'h0011, 1'b1, 1'b0);
    chk("R6 pulse ends", 32'(word_vld_o), 32'd0);
    step(1'b1, 3'd4, 16'h0022, 1'b1, 1'b0);
    chk("R3 word 2", word_o, exp_slot(1, 0, 3'd2, 16'h11, 1'b1) |
                            exp_slot(1, 1, 3'd4, 16'h22, 1'b1));
  endtask

  task automatic t_narrow4();
    do_reset(2'd0, 2'd0);
    step(1'b1, 3'd1, 16'hFFF5, 1'b1, 1'b0);
    step(1'b1, 3'd2, 16'hABCA, 1'b0, 1'b0);
    chk("R4 no word after two", 32'(word_vld_o), 32'd0);
    step(1'b1, 3'd7, 16'h8003, 1'b1, 1'b0);
    chk("R4 vld", 32'(word_vld_o), 32'd1);
    chk("R4 R7 word", word_o, exp_slot(0, 0, 3'd1, 16'h5, 1'b1) |
                             exp_slot(0, 1, 3'd2, 16'hA, 1'b0) |
                             exp_slot(0, 2, 3'd7, 16'h3, 1'b1));
    chk("R7 top zero", 32'(word_o[31:24]), 32'd0);
  endtask

  task automatic t_styles();
    do_reset(2'd1, 2'd1);
    chk("R5 demux 8 ok", 32'(cfg_bad_o), 32'd0);
    step(1'b1, 3'd5, 16'h0077, 1'b0, 1'b0);
    step(1'b1, 3'd6, 16'h0088, 1'b1, 1'b0);
    chk("R5 demux word", word_o, exp_slot(1, 0, 3'd5, 16'h77, 1'b0) |
                                exp_slot(1, 1, 3'd6, 16'h88, 1'b1));
    do_reset(2'd1, 2'd2);
    idle();
    chk("R5 mux refused", 32'(cfg_bad_o), 32'd1);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 3'd1, 16'h1, 1'b1, 1'b0);
      chk("R5 mux no word", 32'(word_vld_o), 32'd0);
    end
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
    chk("R8 R5 flush nothing", 32'(word_vld_o), 32'd0);
    do_reset(2'd0, 2'd1);
    idle();
    chk("R5 demux 4 refused", 32'(cfg_bad_o), 32'd1);
    do_reset(2'd3, 2'd0);
    idle();
    chk("R5 width 3 refused", 32'(cfg_bad_o), 32'd1);
    // recover through a flush (R9)
    mode_i = 2'd2;
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
    step(1'b1, 3'd4, 16'h4321, 1'b0, 1'b0);
    chk("R9 recovered cfg", 32'(cfg_bad_o), 32'd0);
    chk("R9 recovered word", word_o, exp_slot(2, 0, 3'd4, 16'h4321, 1'b0));
  endtask

  task automatic t_flush();
    do_reset(2'd0, 2'd0);
    step(1'b1, 3'd3, 16'h9, 1'b1, 1'b0);
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
    chk("R8 partial vld", 32'(word_vld_o), 32'd1);
    chk("R8 partial word", word_o, exp_slot(0, 0, 3'd3, 16'h9, 1'b1));
    step(1'b1, 3'd6, 16'h2, 1'b0, 1'b0);
    step(1'b1, 3'd5, 16'hC, 1'b1, 1'b1);
    chk("R8 flush with sample", word_o, exp_slot(0, 0, 3'd6, 16'h2, 1'b0) |
                                       exp_slot(0, 1, 3'd5, 16'hC, 1'b1));
    step(1'b1, 3'd1, 16'h1, 1'b0, 1'b0);
    step(1'b1, 3'd2, 16'h2, 1'b0, 1'b0);
    chk("R8 restart no early word", 32'(word_vld_o), 32'd0);
    step(1'b1, 3'd3, 16'h3, 1'b0, 1'b0);
    chk("R8 restart slot 0", word_o, exp_slot(0, 0, 3'd1, 16'h1, 1'b0) |
                                    exp_slot(0, 1, 3'd2, 16'h2, 1'b0) |
                                    exp_slot(0, 2, 3'd3, 16'h3, 1'b0));
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
    chk("R8 empty flush", 32'(word_vld_o), 32'd0);
  endtask

  task automatic t_mode_change();
    do_reset(2'd0, 2'd0);
    step(1'b1, 3'd1, 16'h4, 1'b0, 1'b0);
    mode_i = 2'd2;
    step(1'b1, 3'd2, 16'h5, 1'b1, 1'b0);
    chk("R9 change ignored", 32'(word_vld_o), 32'd0);
    step(1'b1, 3'd3, 16'h6, 1'b0, 1'b0);
    chk("R9 old layout", word_o, exp_slot(0, 0, 3'd1, 16'h4, 1'b0) |
                                exp_slot(0, 1, 3'd2, 16'h5, 1'b1) |
                                exp_slot(0, 2, 3'd3, 16'h6, 1'b0));
    step(1'b1, 3'd7, 16'hF, 1'b1, 1'b0);
    chk("R9 still narrow", 32'(word_vld_o), 32'd0);
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
    chk("R9 flushed narrow", word_o, exp_slot(0, 0, 3'd7, 16'hF, 1'b1));
    step(1'b1, 3'd2, 16'hDEAD, 1'b1, 1'b0);
    chk("R9 new layout vld", 32'(word_vld_o), 32'd1);
    chk("R9 new layout", word_o, exp_slot(2, 0, 3'd2, 16'hDEAD, 1'b1));
  endtask

  task automatic t_idle_gaps();
    do_reset(2'd1, 2'd0);
    step(1'b1, 3'd6, 16'h3C, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R10 gap no word", 32'(word_vld_o), 32'd0);
    end
    step(1'b1, 3'd1, 16'hC3, 1'b0, 1'b0);
    chk("R10 word after gaps", word_o, exp_slot(1, 0, 3'd6, 16'h3C, 1'b1) |
                                      exp_slot(1, 1, 3'd1, 16'hC3, 1'b0));
  endtask

  initial begin
    t_reset();
    t_wide16();
    t_mid8();
    t_narrow4();
    t_styles();
    t_flush();
    t_mode_change();
    t_idle_gaps();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule